// File: doc/BRIEF.md
# Translation Lookaside Buffer

This block is a small, fully associative cache of recent virtual-to-physical page translations. A lookup presents a virtual page number and, in the same cycle, gets back a hit flag, the physical frame number and the access-permission bits of the matching entry. Every stored entry is compared against the request at once. A write lookup that hits an entry marks that entry as modified. A write lookup to an entry without write permission raises a protection fault instead.

On a miss, the surrounding logic walks the page table and installs the translation through a fill port. The slot that receives the fill is the lowest-numbered empty slot. When no slot is empty, it is the slot under a round-robin pointer. If the displaced entry was valid, its page number and modified flag are reported in the fill cycle, so the page table can record whether the page was written. A flush input empties the whole buffer on a context switch. A flush overrides a fill in the same cycle.

Protection encoding: bit 0 allows reads, bit 1 allows writes and bit 2 allows execution.

Top module: `page_xlat_cache`

## Requirements
- R1: After reset no entry is valid. Every lookup misses, with `lk_hit`=0, `lk_pfn`=0, `lk_prot`=0 and `lk_fault`=0.
- R2: A lookup whose page number matches a valid entry returns `lk_hit`=1 and that entry's frame number and protection bits combinationally, in the same cycle.
- R3: A write lookup (`lk_write`=1) that hits an entry whose protection bit 1 is 0 drives `lk_fault`=1 in the same cycle. It does not mark the entry modified.
- R4: A write lookup that hits an entry whose protection bit 1 is 1 sets that entry's modified flag at the next clock edge, and gives `lk_fault`=0.
- R5: A lookup that matches no valid entry drives `lk_hit`=0, `lk_pfn`=0, `lk_prot`=0 and `lk_fault`=0. At most one entry matches at a time.
- R6: An accepted fill goes to the lowest-indexed invalid slot if one exists, and otherwise to the slot at the round-robin pointer. The pointer resets to 0, advances by one (wrapping after the last slot) on every accepted fill, and is left unchanged by a flush.
- R7: In the cycle of an accepted fill whose target slot holds a valid entry, `ev_valid`=1, `ev_vpn` gives that entry's page number and `ev_dirty` gives its modified flag. Otherwise `ev_valid`=0, `ev_vpn`=0 and `ev_dirty`=0. A filled entry starts unmodified.
- R8: `flush` invalidates every entry at the next edge. A fill in the same cycle is dropped: no eviction is reported and the pointer does not move.
- R9: A lookup in the same cycle as a fill sees the contents from before the fill. The new entry is visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_write | input | 1 | Lookup is for a write access |
| lk_vpn | input | VPN_W | Requested virtual page number |
| lk_hit | output | 1 | Translation found |
| lk_pfn | output | PFN_W | Physical frame number on hit |
| lk_prot | output | PROT_W | Protection bits on hit |
| lk_fault | output | 1 | Write to a non-writable page |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Page number to install |
| fill_pfn | input | PFN_W | Frame number to install |
| fill_prot | input | PROT_W | Protection bits to install |
| ev_valid | output | 1 | A valid entry is displaced this cycle |
| ev_vpn | output | VPN_W | Page number of the displaced entry |
| ev_dirty | output | 1 | Modified flag of the displaced entry |

## Verification
The bench drives a write hit on a writable page and then forces that slot out, expecting a dirty eviction report. A design that dropped the modified flag would report a clean page, and that written page would be lost. A write to a read-only page is evicted the same way: a design that marked it modified despite the fault would report it dirty. A fill and a flush are raised together and the buffer is then refilled past capacity. This checks that the dropped fill neither landed nor moved the round-robin pointer, since a wrong pointer evicts the wrong page. A fill with a concurrent lookup of the same page exposes any design that forwards the new entry combinationally.

// File: rtl/pxc_pkg.sv
package pxc_pkg;
  // Protection bit positions
  localparam int PROT_RD = 0;
  localparam int PROT_WR = 1;
  localparam int PROT_EX = 2;
endpackage

// File: rtl/pxc_match.sv
module pxc_match #(
  parameter int N     = 8,
  parameter int VPN_W = 20
) (
  input  logic                      req,
  input  logic [VPN_W-1:0]          vpn,
  input  logic [N-1:0][VPN_W-1:0]   tags,
  input  logic [N-1:0]              valid,
  output logic [N-1:0]              hit_vec
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign hit_vec[i] = req && valid[i] && (tags[i] == vpn);
  end
endmodule

// File: rtl/pxc_victim.sv
module pxc_victim #(
  parameter int N = 8,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N-1:0]     valid,
  input  logic             fill_fire,
  output logic [IDX_W-1:0] victim_idx,
  output logic [N-1:0]     victim_oh
);
  logic [IDX_W-1:0] ptr_q;

  function automatic logic [IDX_W-1:0] lowest_free(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [IDX_W-1:0] step(input logic [IDX_W-1:0] p);
    return (p == IDX_W'(N - 1)) ? '0 : p + 1'b1;
  endfunction

  assign victim_idx = (&valid) ? ptr_q : lowest_free(valid);
  assign victim_oh  = N'(1) << victim_idx;

  always_ff @(posedge clk) begin
    if (!rst_n)         ptr_q <= '0;
    else if (fill_fire) ptr_q <= step(ptr_q);
  end
endmodule

// File: rtl/page_xlat_cache.sv
module page_xlat_cache #(
  parameter int ENTRIES = 8,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 16,
  parameter int PROT_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              lk_valid,
  input  logic              lk_write,
  input  logic [VPN_W-1:0]  lk_vpn,
  output logic              lk_hit,
  output logic [PFN_W-1:0]  lk_pfn,
  output logic [PROT_W-1:0] lk_prot,
  output logic              lk_fault,
  input  logic              fill_valid,
  input  logic [VPN_W-1:0]  fill_vpn,
  input  logic [PFN_W-1:0]  fill_pfn,
  input  logic [PROT_W-1:0] fill_prot,
  output logic              ev_valid,
  output logic [VPN_W-1:0]  ev_vpn,
  output logic              ev_dirty
);
  import pxc_pkg::*;
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  logic [ENTRIES-1:0][VPN_W-1:0]  tag_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [ENTRIES-1:0][PROT_W-1:0] prot_q;
  logic [ENTRIES-1:0]             valid_q;
  logic [ENTRIES-1:0]             dirty_q;

  // Named internal events for the checker
  logic [ENTRIES-1:0] hit_vec;
  logic [ENTRIES-1:0] victim_oh;
  logic [IDX_W-1:0]   victim_idx;
  logic [IDX_W-1:0]   hit_idx;
  logic               fill_fire;
  logic               wr_mark;

  function automatic logic [IDX_W-1:0] oh_to_idx(input logic [ENTRIES-1:0] oh);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (oh[i]) r = r | IDX_W'(i);
    end
    return r;
  endfunction

  pxc_match #(.N(ENTRIES), .VPN_W(VPN_W)) u_match (
    .req(lk_valid), .vpn(lk_vpn), .tags(tag_q), .valid(valid_q), .hit_vec(hit_vec)
  );

  pxc_victim #(.N(ENTRIES)) u_victim (
    .clk(clk), .rst_n(rst_n), .valid(valid_q), .fill_fire(fill_fire),
    .victim_idx(victim_idx), .victim_oh(victim_oh)
  );

  assign hit_idx   = oh_to_idx(hit_vec);
  assign lk_hit    = |hit_vec;
  assign lk_pfn    = lk_hit ? pfn_q[hit_idx]  : '0;
  assign lk_prot   = lk_hit ? prot_q[hit_idx] : '0;
  assign lk_fault  = lk_hit && lk_write && !prot_q[hit_idx][PROT_WR];
  assign wr_mark   = lk_hit && lk_write && prot_q[hit_idx][PROT_WR];

  assign fill_fire = fill_valid && !flush;
  assign ev_valid  = fill_fire && valid_q[victim_idx];
  assign ev_vpn    = ev_valid ? tag_q[victim_idx] : '0;
  assign ev_dirty  = ev_valid && dirty_q[victim_idx];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n || flush) begin
        valid_q[i] <= 1'b0;
        dirty_q[i] <= 1'b0;
      end else if (fill_fire && victim_oh[i]) begin
        valid_q[i] <= 1'b1;
        dirty_q[i] <= 1'b0;
      end else if (wr_mark && hit_vec[i]) begin
        dirty_q[i] <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (fill_fire && victim_oh[i]) begin
        tag_q[i]  <= fill_vpn;
        pfn_q[i]  <= fill_pfn;
        prot_q[i] <= fill_prot;
      end
    end
  end
endmodule

// File: rtl/pxc_checker.sv
module pxc_checker #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         flush,
  input logic         fill_valid,
  input logic         lk_valid,
  input logic         lk_write,
  input logic         lk_hit,
  input logic         lk_fault,
  input logic         ev_valid,
  input logic [N-1:0] hit_vec,
  input logic [N-1:0] valid_vec,
  input logic [N-1:0] dirty_vec,
  input logic [N-1:0] victim_oh
);
  a_r3_fault_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    lk_fault |-> (lk_hit && lk_write));

  a_r3_fault_stays_clean: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_fault && !flush && !fill_valid) |=> ((dirty_vec & $past(hit_vec)) == '0));

  a_r4_write_marks: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_write && lk_hit && !lk_fault && !flush && !fill_valid)
      |=> ((dirty_vec & $past(hit_vec)) != '0));

  a_r5_single_match: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  a_r6_fill_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_valid && !flush) |=> ((valid_vec & $past(victim_oh)) != '0));

  a_r7_evict_needs_fill: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> (fill_valid && !flush));

  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_vec == '0));
endmodule

bind page_xlat_cache pxc_checker #(.N(ENTRIES)) u_pxc_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .fill_valid(fill_valid),
  .lk_valid(lk_valid), .lk_write(lk_write), .lk_hit(lk_hit), .lk_fault(lk_fault),
  .ev_valid(ev_valid), .hit_vec(hit_vec), .valid_vec(valid_q), .dirty_vec(dirty_q),
  .victim_oh(victim_oh)
);

// File: tb/page_xlat_cache_test.sv
module page_xlat_cache_test;
  localparam int N = 8, VW = 20, PW = 16, RW = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic lk_valid = 1'b0, lk_write = 1'b0;
  logic [VW-1:0] lk_vpn = '0;
  logic lk_hit, lk_fault, ev_valid, ev_dirty;
  logic [PW-1:0] lk_pfn;
  logic [RW-1:0] lk_prot;
  logic fill_valid = 1'b0;
  logic [VW-1:0] fill_vpn = '0;
  logic [PW-1:0] fill_pfn = '0;
  logic [RW-1:0] fill_prot = '0;
  logic [VW-1:0] ev_vpn;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // Bench model of the buffer
  logic [VW-1:0] m_vpn [N];
  logic [PW-1:0] m_pfn [N];
  logic [RW-1:0] m_prot [N];
  bit m_val [N];
  bit m_dirty [N];
  int m_ptr = 0;

  always #2 clk = ~clk;

  page_xlat_cache uut (.*);

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    lk_valid = 0; lk_write = 0; fill_valid = 0; flush = 0;
  endtask

  function automatic int find(logic [VW-1:0] vpn);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == vpn) return i;
    return -1;
  endfunction

  task automatic lookup(string req, logic [VW-1:0] vpn, bit wr);
    int k;
    @(negedge clk);
    fill_valid = 0; flush = 0;
    lk_valid = 1; lk_write = wr; lk_vpn = vpn;
    #1;
    k = find(vpn);
    chk(req, "hit", 32'(lk_hit), 32'(k >= 0));
    chk(req, "pfn", 32'(lk_pfn), (k >= 0) ? 32'(m_pfn[k]) : 0);
    chk(req, "prot", 32'(lk_prot), (k >= 0) ? 32'(m_prot[k]) : 0);
    chk(req, "fault", 32'(lk_fault), 32'(k >= 0 && wr && !m_prot[k][1]));
    @(posedge clk);
    if (k >= 0 && wr && m_prot[k][1]) m_dirty[k] = 1;
  endtask

  // Fill, optionally with a same-cycle flush or a same-cycle lookup of the new page
  task automatic fill(string req, logic [VW-1:0] vpn, logic [PW-1:0] pfn,
                      logic [RW-1:0] prot, bit fl, bit look);
    int v;
    bit ev;
    @(negedge clk);
    lk_valid = look; lk_write = 0; lk_vpn = vpn;
    fill_valid = 1; fill_vpn = vpn; fill_pfn = pfn; fill_prot = prot; flush = fl;
    #1;
    v = m_ptr;
    for (int i = N - 1; i >= 0; i--) if (!m_val[i]) v = i;
    ev = !fl && m_val[v];
    chk(req, "ev_valid", 32'(ev_valid), 32'(ev));
    chk(req, "ev_vpn", 32'(ev_vpn), ev ? 32'(m_vpn[v]) : 0);
    chk(req, "ev_dirty", 32'(ev_dirty), 32'(ev && m_dirty[v]));
    if (look) chk("R9", "hit during fill", 32'(lk_hit), 32'(find(vpn) >= 0));
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dirty[i] = 0; end
    end else begin
      m_vpn[v] = vpn; m_pfn[v] = pfn; m_prot[v] = prot;
      m_val[v] = 1; m_dirty[v] = 0;
      m_ptr = (m_ptr + 1) % N;
    end
  endtask

  task automatic t_reset();
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dirty[i] = 0; end
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    lookup("R1", 20'h0, 0);
    lookup("R1", 20'h100, 1);
    idle(); #1;
    chk("R1", "ev_valid idle", 32'(ev_valid), 0);
  endtask

  task automatic t_fill_and_hit();
    for (int i = 0; i < N; i++) begin
      logic [RW-1:0] p;
      p = (i == 2) ? 3'b001 : (i == 5) ? 3'b101 : 3'b011;
      fill("R6", 20'h100 + 20'(i), 16'h40 + 16'(i * 3), p, 0, 0);
    end
    for (int i = 0; i < N; i++) lookup("R2", 20'h100 + 20'(i), 0);
    lookup("R5", 20'h1FF, 0);
    lookup("R5", 20'hABCDE, 1);
  endtask

  task automatic t_write_and_evict();
    lookup("R4", 20'h100, 1);
    lookup("R3", 20'h102, 1);
    lookup("R3", 20'h102, 1);
    fill("R7", 20'h200, 16'h900, 3'b011, 0, 0);  // displaces dirty 0x100
    fill("R7", 20'h201, 16'h901, 3'b011, 0, 0);  // displaces clean 0x101
    fill("R3", 20'h202, 16'h902, 3'b011, 0, 0);  // faulted page must be clean
    lookup("R2", 20'h202, 0);
  endtask

  task automatic t_same_cycle();
    fill("R9", 20'h203, 16'h903, 3'b111, 0, 1);
    lookup("R9", 20'h203, 0);
  endtask

  task automatic t_flush_wins();
    fill("R8", 20'h555, 16'h555, 3'b011, 1, 0);
    lookup("R8", 20'h555, 0);
    lookup("R8", 20'h203, 0);
    lookup("R8", 20'h104, 0);
  endtask

  task automatic t_round_robin();
    for (int i = 0; i < N; i++)
      fill("R6", 20'h300 + 20'(i), 16'h700 + 16'(i), 3'b011, 0, 0);
    lookup("R4", 20'h304, 1);
    fill("R6", 20'h400, 16'hA00, 3'b001, 0, 0);  // pointer slot holds 0x304
    fill("R6", 20'h401, 16'hA01, 3'b001, 0, 0);
    lookup("R2", 20'h400, 0);
    lookup("R5", 20'h304, 0);
    @(negedge clk); flush = 1; fill_valid = 0; lk_valid = 0;
    @(posedge clk);
    for (int i = 0; i < N; i++) begin m_val[i] = 0; m_dirty[i] = 0; end
    lookup("R8", 20'h400, 0);
  endtask

  initial begin
    t_reset();
    t_fill_and_hit();
    t_write_and_evict();
    t_same_cycle();
    t_flush_wins();
    t_round_robin();
    idle();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule